// File: doc/BRIEF.md
# Phase-aligned clock divider with run gating

This block turns one input clock into three slower clocks at one-half, one-quarter and one-eighth of the input rate. All three come from a single synchronous counter chain that is clocked by the input clock, so every output edge comes from the same rising input edge. Where output edges fall at the same time, they are aligned.

A run control lets the chain count or freeze. The control is sampled on the falling input edge. The chain therefore starts or stops only while the input clock is low, and a shortened pulse can never upset one stage relative to another. An active-high phase reset clears the chain to a known common phase at any moment. Several copies of the block that share that reset and their run control then produce identical outputs.

Top module: `syncdiv_clkgen`

## Requirements
- R1: While the registered run state is 1, `div2_o` inverts on every rising edge of `clk_in`, giving a period of 2 enabled input cycles.
- R2: `div4_o` inverts on an enabled rising edge exactly when `div2_o` is 1 before that edge, giving a period of 4 enabled input cycles.
- R3: `div8_o` inverts on an enabled rising edge exactly when `div2_o` and `div4_o` are both 1 before that edge, giving a period of 8 enabled input cycles.
- R4: `div4_o` never changes on an edge where `div2_o` stays unchanged. `div8_o` never changes on an edge where `div4_o` and `div2_o` do not also change.
- R5: `run_en` is captured only on the falling edge of `clk_in`. A change of `run_en` that starts after a falling edge and is undone before the next falling edge has no effect on the outputs.
- R6: While the registered run state is 0, all three outputs hold their levels on every rising edge.
- R7: After a freeze, counting resumes from the held state. Every high or low phase of `div2_o`, `div4_o` and `div8_o` lasts exactly 1, 2 and 4 enabled rising edges respectively, across any pattern of run changes.
- R8: `phase_rst` = 1 drives all outputs to 0 at once, without waiting for a clock edge. It also clears the registered run state, so no rising edge counts until a falling edge has seen `run_en` = 1 after the reset is released.
- R9: After reset is released and a falling edge has seen `run_en` = 1, the next rising edge sets `div2_o` to 1 while `div4_o` and `div8_o` stay 0.
- R10: Two instances that were in different phases produce identical outputs on every cycle after they are reset together and driven with the same `run_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided |
| run_en | input | 1 | Run control, sampled on the falling edge of `clk_in` |
| phase_rst | input | 1 | Active-high asynchronous reset to the common phase |
| div2_o | output | 1 | Input clock divided by 2 |
| div4_o | output | 1 | Input clock divided by 4 |
| div8_o | output | 1 | Input clock divided by 8 |

## Verification
The run capture on the falling edge and the release of the phase reset can fall within the same input period. The bench provokes this in two ways: it releases the reset just after a falling edge while `run_en` is already high, and it releases the reset mid-period before the falling edge. The reference model then expects one idle rising edge in the first case and an immediate count in the second.

Run changes are also driven at random, so a freeze often lands on the carry edge where all three outputs invert together. Each edge is judged against a behavioural counter model. Every output phase is also measured in enabled edges.

// File: rtl/syncdiv_pkg.sv
package syncdiv_pkg;
  // number of binary divide stages (2, 4, 8)
  parameter int unsigned DIV_STAGES = 3;
  typedef logic [DIV_STAGES-1:0] stage_vec_t;
endpackage

// File: rtl/syncdiv_run_capture.sv
// Samples the run control on the falling clock edge so the chain is only
// started or stopped while the input clock is low.
module syncdiv_run_capture #(
  parameter bit CLEAR_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic run_in,
  output logic run_q
);
  always_ff @(negedge clk or posedge rst) begin
    if (rst) run_q <= CLEAR_VAL;
    else     run_q <= run_in;
  end
endmodule

// File: rtl/syncdiv_toggle_stage.sv
// One divide-by-two flop with a synchronous toggle request.
module syncdiv_toggle_stage (
  input  logic clk,
  input  logic rst,
  input  logic tog,
  output logic q
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst)      q <= 1'b0;
    else if (tog) q <= ~q;
  end
endmodule

// File: rtl/syncdiv_chain.sv
// Synchronous binary chain: every stage sits on the same clock, and a stage
// toggles when the run state is set and all lower stages are 1.
module syncdiv_chain #(
  parameter int unsigned STAGES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  output logic [STAGES-1:0] q
);
  logic [STAGES-1:0] tog;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign tog[i] = run;
    end else begin : g_upper
      assign tog[i] = tog[i-1] & q[i-1];
    end
    syncdiv_toggle_stage u_stage (
      .clk (clk),
      .rst (rst),
      .tog (tog[i]),
      .q   (q[i])
    );
  end
endmodule

// File: rtl/syncdiv_clkgen.sv
module syncdiv_clkgen
  import syncdiv_pkg::*;
(
  input  logic clk_in,
  input  logic run_en,
  input  logic phase_rst,
  output logic div2_o,
  output logic div4_o,
  output logic div8_o
);
  localparam int unsigned STAGES = DIV_STAGES;

  logic       en_q;
  stage_vec_t stages;

  syncdiv_run_capture #(.CLEAR_VAL(1'b0)) u_run (
    .clk    (clk_in),
    .rst    (phase_rst),
    .run_in (run_en),
    .run_q  (en_q)
  );

  syncdiv_chain #(.STAGES(STAGES)) u_chain (
    .clk (clk_in),
    .rst (phase_rst),
    .run (en_q),
    .q   (stages)
  );

  assign div2_o = stages[0];
  assign div4_o = stages[1];
  assign div8_o = stages[2];
endmodule

// File: rtl/syncdiv_clkgen_chk.sv
module syncdiv_clkgen_chk (
  input logic clk,
  input logic mrst,
  input logic en_q,
  input logic div2,
  input logic div4,
  input logic div8
);
  AST_DIV2_TOGGLES: assert property (@(posedge clk) disable iff (mrst)
    en_q |=> (div2 != $past(div2))); // R1

  AST_DIV4_CARRY: assert property (@(posedge clk) disable iff (mrst)
    (en_q && div2) |=> (div4 != $past(div4))); // R2

  AST_DIV4_HOLD: assert property (@(posedge clk) disable iff (mrst)
    (en_q && !div2) |=> $stable(div4)); // R2

  AST_DIV8_CARRY: assert property (@(posedge clk) disable iff (mrst)
    (en_q && div2 && div4) |=> (div8 != $past(div8))); // R3

  AST_EDGES_ALIGNED: assert property (@(posedge clk) disable iff (mrst)
    (div8 != $past(div8)) |-> ((div4 != $past(div4)) && (div2 != $past(div2)))); // R4

  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (mrst)
    !en_q |=> $stable({div8, div4, div2})); // R6

  AST_RESET_CLEARS: assert property (@(negedge clk)
    mrst |-> (!div2 && !div4 && !div8 && !en_q)); // R8
endmodule

bind syncdiv_clkgen syncdiv_clkgen_chk u_chk (
  .clk  (clk_in),
  .mrst (phase_rst),
  .en_q (en_q),
  .div2 (div2_o),
  .div4 (div4_o),
  .div8 (div8_o)
);

// File: tb/syncdiv_clkgen_bench.sv
module syncdiv_clkgen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 200000;

  logic clk = 1'b0;
  logic run_en, phase_rst, run_en_b, rst_b, tie_peer;
  logic div2_o, div4_o, div8_o;
  logic p_div2, p_div4, p_div8;
  logic peer_en;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign peer_en = tie_peer ? run_en : run_en_b;

  syncdiv_clkgen u_syncdiv_clkgen (
    .clk_in (clk), .run_en (run_en), .phase_rst (phase_rst),
    .div2_o (div2_o), .div4_o (div4_o), .div8_o (div8_o)
  );

  syncdiv_clkgen u_syncdiv_clkgen_peer (
    .clk_in (clk), .run_en (peer_en), .phase_rst (rst_b),
    .div2_o (p_div2), .div4_o (p_div4), .div8_o (p_div8)
  );

  // behavioural reference: a run flag seen at falling edges, a plain count
  logic       m_en;
  logic [2:0] m_cnt;
  int         since [3];
  logic [2:0] prev;

  always @(negedge clk or posedge phase_rst) begin
    if (phase_rst) m_en <= 1'b0;
    else           m_en <= run_en;
  end

  always @(posedge clk or posedge phase_rst) begin
    if (phase_rst) begin
      m_cnt <= 3'd0;
      for (int k = 0; k < 3; k++) since[k] <= 0;
    end else if (m_en) begin
      m_cnt <= m_cnt + 3'd1;
      for (int k = 0; k < 3; k++) since[k] <= since[k] + 1;
    end
  end

  function automatic logic [2:0] outs();
    return {div8_o, div4_o, div2_o};
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic tick();
    logic [2:0] cur;
    @(posedge clk);
    #1;
    cur = outs();
    check("R1 div2 vs model", int'(div2_o), int'(m_cnt[0]));
    check("R2 div4 vs model", int'(div4_o), int'(m_cnt[1]));
    check("R3 div8 vs model", int'(div8_o), int'(m_cnt[2]));
    if (!phase_rst) begin
      if (cur[2] != prev[2])
        check("R4 div8 edge aligned", int'(cur[1] != prev[1] && cur[0] != prev[0]), 1);
      if (cur[1] != prev[1])
        check("R4 div4 edge aligned", int'(cur[0] != prev[0]), 1);
      for (int k = 0; k < 3; k++) begin
        if (cur[k] != prev[k]) begin
          check($sformatf("R7 phase length stage %0d", k), since[k], 1 << k);
          since[k] = 0;
        end
      end
      prev = cur;
    end else begin
      prev = 3'b000;
    end
    if (tie_peer)
      check("R10 peer in phase", int'({p_div8, p_div4, p_div2}), int'(cur));
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYCLES);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    logic [2:0] snap;
    phase_rst = 1'b1; rst_b = 1'b1; run_en = 1'b0; run_en_b = 1'b0; tie_peer = 1'b0;
    prev = 3'b000;
    repeat (3) tick();
    check("R8 reset state", int'(outs()), 0);

    // release with run already high: first counting edge sets div2 only
    run_en = 1'b1; run_en_b = 1'b1; phase_rst = 1'b0;
    tick();
    check("R9 first edge after release", int'(outs()), 1);
    repeat (2) tick();
    rst_b = 1'b0;              // peer starts later, out of phase
    repeat (24) tick();

    // random run pattern
    repeat (200) begin
      run_en = 1'($urandom_range(0, 1));
      tick();
    end

    // freeze
    run_en = 1'b0;
    tick();
    snap = outs();
    repeat (5) begin
      tick();
      check("R6 hold while frozen", int'(outs()), int'(snap));
    end

    // short high pulse between falling edges is ignored
    @(negedge clk); #1 run_en = 1'b1;
    tick();
    check("R5 pulse after falling edge ignored", int'(outs()), int'(snap));
    run_en = 1'b0;
    tick();
    check("R5 still frozen", int'(outs()), int'(snap));

    // resume
    run_en = 1'b1;
    repeat (12) tick();

    // short low dip between falling edges is ignored
    @(negedge clk); #1 run_en = 1'b0;
    snap = outs();
    tick();
    check("R5 dip ignored, first edge", int'(outs()), int'(snap + 3'd1));
    run_en = 1'b1;
    tick();
    check("R5 dip ignored, second edge", int'(outs()), int'(snap + 3'd2));

    // asynchronous reset mid-period, both instances together
    repeat (3) tick();
    #2 phase_rst = 1'b1; rst_b = 1'b1;
    #1 check("R8 async clear before edge", int'(outs()), 0);
    check("R8 async clear peer", int'({p_div8, p_div4, p_div2}), 0);
    tick();
    tick();
    run_en = 1'b1;
    @(negedge clk); #1 phase_rst = 1'b0; rst_b = 1'b0; tie_peer = 1'b1;
    tick();
    check("R8 run cleared until falling edge", int'(outs()), 0);
    tick();
    check("R9 div2 rises first", int'(outs()), 1);

    repeat (60) begin
      run_en = 1'($urandom_range(0, 1));
      tick();
    end
    run_en = 1'b1;
    repeat (16) tick();

    report();
    $finish;
  end
endmodule